// File: doc/BRIEF.md
# Gated Frequency Meter

This block measures the frequency of an external digital signal by counting its rising edges over a fixed measurement window. The window is timed by a slow time-base strobe that arrives at 75 kHz in the target system. The host first writes a small configuration register, which holds a 2-bit mode field and a 2-bit window-length field. It then issues a one-cycle start command. The block clears its previous result and opens the window. It counts every synchronised rising edge of the input while the window is open, then closes the window and raises a completion flag. The count stays on the result port until the next start command.

The input passes through a synchroniser and an edge detector that run on the fast block clock. That clock must be at least twice the highest input rate to be measured (12 MHz in the target system). A level input, `count_block_i`, stands for the low-power, halt and oscillator-stop states. While it is high, input edges are dropped but the window keeps running. The result is a plain status readout with no back-pressure. It is meaningful whenever `done_o` is high, and it does not change again until a new start command is accepted.

Top module: `fm_freq_meter`

## Requirements
- R1: After reset, `result_o` is 0, and `done_o`, `ovf_o` and `busy_o` are all 0. The stored mode field is 00 and the stored window code is 00.
- R2: The window code selects the window length in time-base strobes: 00 → 75, 01 → 300, 10 → 600, 11 → 2400. `busy_o` rises in the cycle after an accepted start. `done_o` rises, and `busy_o` falls, at the clock edge that samples the Nth `tick_i` pulse after the start.
- R3: `result_o` equals the number of rising edges of `sig_i` detected while the window is open. An edge is detected at the third clock edge after the rise is set up. The result holds unchanged after the window closes, including when further input edges arrive, until the next accepted start.
- R4: A start is accepted only when the stored mode field is 00 (frequency measurement). A start given under any other mode changes neither `done_o`, `busy_o` nor `result_o`.
- R5: An accepted start clears `done_o`, `result_o` and `ovf_o` in the next cycle. A start accepted while a window is open restarts the window and the count from zero.
- R6: While `count_block_i` is high, detected edges are not counted. The window timing continues unaffected.
- R7: The count saturates at all ones (0xFFFFF at the default width) instead of wrapping. An edge arriving when the count is already all ones sets `ovf_o`, which stays set until the next accepted start.
- R8: The window code is captured at the accepted start. Configuration writes made during an open window take effect only for the next measurement.
- R9: `busy_o` and `done_o` are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, at least twice the highest input rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Write strobe for the configuration register |
| cfg_mode_i | input | 2 | Mode field; 00 selects frequency measurement |
| cfg_gate_i | input | 2 | Window-length code (see R2) |
| start_i | input | 1 | One-cycle start command |
| tick_i | input | 1 | One-cycle time-base strobe (75 kHz in the target system) |
| count_block_i | input | 1 | High in low-power, halt or stop states; blocks counting |
| sig_i | input | 1 | Asynchronous signal whose frequency is measured |
| busy_o | output | 1 | Window open |
| done_o | output | 1 | Measurement complete flag |
| result_o | output | CNT_W (20) | Edge count of the last measurement |
| ovf_o | output | 1 | Count saturated |

## Verification
A window-length counter that drifts shows up as `done_o` rising outside the strobe window for the selected code. This is visible on the very measurement it affects. A stuck or wrongly gated edge enable shows as a wrong `result_o` once `done_o` rises. A counter that wraps instead of saturating shows on a narrow-width copy within a few dozen edges, as a small result with `ovf_o` low. Leaked clear or hold logic shows as `done_o`, `ovf_o` or `result_o` changing within one cycle of an ignored start or of edges that arrive after the window has closed.

// File: rtl/fm_pkg.sv
package fm_pkg;

  typedef enum logic [1:0] {
    GATE_C0 = 2'b00,
    GATE_C1 = 2'b01,
    GATE_C2 = 2'b10,
    GATE_C3 = 2'b11
  } gate_code_e;

  localparam logic [1:0] MODE_FREQ = 2'b00;

  function automatic int unsigned gate_ticks(
    input gate_code_e  code,
    input int unsigned t0,
    input int unsigned t1,
    input int unsigned t2,
    input int unsigned t3
  );
    case (code)
      GATE_C0: return t0;
      GATE_C1: return t1;
      GATE_C2: return t2;
      default: return t3;
    endcase
  endfunction

  function automatic int unsigned max4(
    input int unsigned a,
    input int unsigned b,
    input int unsigned c,
    input int unsigned d
  );
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/fm_sync_edge.sv
module fm_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);

  logic [STAGES-1:0] stg_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[0] <= 1'b0;
          else        stg_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[g] <= 1'b0;
          else        stg_q[g] <= stg_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= stg_q[STAGES-1];
  end

  assign rise_o = stg_q[STAGES-1] & ~prev_q;

  // a rising edge pulse never lasts two cycles
  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/fm_gate_timer.sv
module fm_gate_timer #(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_i,
  input  logic          tick_i,
  input  logic [TW-1:0] lim_m1_i,
  output logic          busy_o,
  output logic          close_o
);

  logic [TW-1:0] tcnt_q;
  logic          busy_q;
  logic          last_tick;

  assign last_tick = busy_q && tick_i && (tcnt_q == lim_m1_i);
  assign close_o   = last_tick && !go_i;
  assign busy_o    = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      tcnt_q <= '0;
    end else if (go_i) begin
      busy_q <= 1'b1;
      tcnt_q <= '0;
    end else if (busy_q && tick_i) begin
      if (last_tick) begin
        busy_q <= 1'b0;
        tcnt_q <= '0;
      end else begin
        tcnt_q <= tcnt_q + 1'b1;
      end
    end
  end

  // the strobe counter never runs past the selected window
  assert_gate_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (tcnt_q <= lim_m1_i));

  // an idle timer does not move its counter
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !go_i) |=> (tcnt_q == '0));

endmodule

// File: rtl/fm_event_counter.sv
module fm_event_counter #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o
);

  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt_q;
  logic         ovf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (inc_i) begin
      if (cnt_q == CNT_MAX) ovf_q <= 1'b1;
      else                  cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  // saturation is sticky and the count stays at the top
  assert_sat_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clr_i) |=> (ovf_q && cnt_q == CNT_MAX));

  // overflow is only ever seen with a full count
  assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> (cnt_q == CNT_MAX));

endmodule

// File: rtl/fm_freq_meter.sv
module fm_freq_meter
  import fm_pkg::*;
#(
  parameter int          CNT_W       = 20,
  parameter int          SYNC_STAGES = 2,
  parameter int unsigned TICKS_C0    = 75,
  parameter int unsigned TICKS_C1    = 300,
  parameter int unsigned TICKS_C2    = 600,
  parameter int unsigned TICKS_C3    = 2400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_mode_i,
  input  logic [1:0]       cfg_gate_i,
  input  logic             start_i,
  input  logic             tick_i,
  input  logic             count_block_i,
  input  logic             sig_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] result_o,
  output logic             ovf_o
);

  localparam int unsigned TICKS_MAX = max4(TICKS_C0, TICKS_C1, TICKS_C2, TICKS_C3);
  localparam int          TW        = $clog2(TICKS_MAX + 1);

  logic [1:0]    mode_q;
  gate_code_e    gate_q;
  gate_code_e    gate_run_q;
  logic          done_q;
  logic          go;
  logic          rise;
  logic          close;
  logic          busy;
  logic          inc;
  logic [TW-1:0] lim_m1;

  // configuration register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_FREQ;
      gate_q <= GATE_C0;
    end else if (cfg_we_i) begin
      mode_q <= cfg_mode_i;
      gate_q <= gate_code_e'(cfg_gate_i);
    end
  end

  assign go = start_i && (mode_q == MODE_FREQ);

  // window code captured at start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  gate_run_q <= GATE_C0;
    else if (go) gate_run_q <= gate_q;
  end

  assign lim_m1 = TW'(gate_ticks(gate_run_q, TICKS_C0, TICKS_C1, TICKS_C2, TICKS_C3) - 1);

  fm_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(sig_i),
    .rise_o (rise)
  );

  fm_gate_timer #(.TW(TW)) u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .go_i    (go),
    .tick_i  (tick_i),
    .lim_m1_i(lim_m1),
    .busy_o  (busy),
    .close_o (close)
  );

  assign inc = busy && rise && !count_block_i;

  fm_event_counter #(.W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr_i(go),
    .inc_i(inc),
    .cnt_o(result_o),
    .ovf_o(ovf_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     done_q <= 1'b0;
    else if (go)    done_q <= 1'b0;
    else if (close) done_q <= 1'b1;
  end

  assign done_o = done_q;
  assign busy_o = busy;

  assert_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done_q));

  assert_mode_ignore_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && mode_q != MODE_FREQ && !busy) |=> (done_q == $past(done_q) && !busy));

  assert_start_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (!done_q && result_o == '0 && !ovf_o && busy));

  assert_block_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (count_block_i && !go) |=> $stable(result_o));

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !go) |=> $stable(result_o));

endmodule

// File: tb/test_fm_freq_meter.sv
module test_fm_freq_meter;

  localparam int TDIV  = 6;
  localparam int SW    = 4;
  localparam int SMAX  = (1 << SW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we_i = 1'b0;
  logic [1:0] cfg_mode_i = 2'b00;
  logic [1:0] cfg_gate_i = 2'b00;
  logic start_i = 1'b0;
  logic tick_i = 1'b0;
  logic count_block_i = 1'b0;
  logic sig_i = 1'b0;
  logic busy_o, done_o, ovf_o;
  logic [19:0] result_o;
  logic busy_s, done_s, ovf_s;
  logic [SW-1:0] result_s;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int tph = 0;

  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // time-base strobe: one cycle high every TDIV cycles
  always @(negedge clk) begin
    tph    <= (tph == TDIV - 1) ? 0 : tph + 1;
    tick_i <= (tph == TDIV - 1);
  end

  fm_freq_meter i_fm_freq_meter (
    .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we_i), .cfg_mode_i(cfg_mode_i),
    .cfg_gate_i(cfg_gate_i), .start_i(start_i), .tick_i(tick_i),
    .count_block_i(count_block_i), .sig_i(sig_i), .busy_o(busy_o),
    .done_o(done_o), .result_o(result_o), .ovf_o(ovf_o));

  fm_freq_meter #(.CNT_W(SW)) i_fm_freq_meter_sat (
    .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we_i), .cfg_mode_i(cfg_mode_i),
    .cfg_gate_i(cfg_gate_i), .start_i(start_i), .tick_i(tick_i),
    .count_block_i(count_block_i), .sig_i(sig_i), .busy_o(busy_s),
    .done_o(done_s), .result_o(result_s), .ovf_o(ovf_s));

  function automatic int ticks_of(input int code);
    case (code)
      0: return 75;
      1: return 300;
      2: return 600;
      default: return 2400;
    endcase
  endfunction

  function automatic int sat_of(input int n);
    return (n > SMAX) ? SMAX : n;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_cfg(input int mode, input int gate);
    cfg_mode_i = mode[1:0];
    cfg_gate_i = gate[1:0];
    cfg_we_i   = 1'b1;
    @(negedge clk);
    cfg_we_i   = 1'b0;
  endtask

  task automatic do_start(output int t0);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    t0 = cyc;
  endtask

  // one input pulse, optionally under count blocking; returns 1 when counted
  task automatic pulse(input bit blk, output int counted);
    count_block_i = blk;
    repeat (3) @(negedge clk);
    sig_i = 1'b1;
    repeat (2) @(negedge clk);
    sig_i = 1'b0;
    repeat (5) @(negedge clk);
    count_block_i = 1'b0;
    counted = blk ? 0 : 1;
  endtask

  task automatic wait_done(input int t0, input int code);
    int w;
    int k;
    w = 0;
    while (!done_o && w < 20000) begin
      @(negedge clk);
      w++;
    end
    k = cyc - t0;
    check(done_o === 1'b1 && k >= (ticks_of(code) - 1) * TDIV + 1 && k <= ticks_of(code) * TDIV,
          "R2 window length", k, ticks_of(code) * TDIV);
    check(busy_o === 1'b0, "R9 busy low when done", busy_o, 0);
  endtask

  task automatic run_meas(input bit do_cfg, input int code, input int k, input int blk_pct);
    int t0;
    int exp_n;
    int c;
    exp_n = 0;
    if (do_cfg) write_cfg(0, code);
    do_start(t0);
    check(done_o === 1'b0 && result_o === 20'd0 && ovf_o === 1'b0, "R5 start clears", done_o, 0);
    for (int i = 0; i < k; i++) begin
      pulse(($urandom % 100) < blk_pct, c);
      exp_n += c;
    end
    wait_done(t0, code);
    check(result_o == 20'(exp_n), "R3 R6 count", result_o, exp_n);
    check(ovf_o === 1'b0, "R7 no ovf main", ovf_o, 0);
    check(result_s == SW'(sat_of(exp_n)), "R7 saturated count", result_s, sat_of(exp_n));
    check(ovf_s === (exp_n > SMAX), "R7 ovf flag", ovf_s, exp_n > SMAX);
  endtask

  initial begin
    int t0;
    int c;
    int held;
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    check(result_o === 20'd0 && done_o === 1'b0 && ovf_o === 1'b0 && busy_o === 1'b0,
          "R1 reset outputs", result_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(done_o === 1'b0 && busy_o === 1'b0, "R1 idle after reset", done_o, 0);

    // R1: default config is frequency mode, shortest window
    do_start(t0);
    check(busy_o === 1'b1, "R1 default mode accepts start", busy_o, 1);
    for (int i = 0; i < 4; i++) pulse(1'b0, c);
    wait_done(t0, 0);
    check(result_o == 20'd4, "R1 R3 default window count", result_o, 4);

    // R7: more edges than the narrow copy can hold
    run_meas(1'b1, 1, 25, 0);

    // R3: edges after the window closes leave the result alone
    held = result_o;
    for (int i = 0; i < 3; i++) pulse(1'b0, c);
    check(result_o == 20'(held) && done_o === 1'b1, "R3 hold after close", result_o, held);

    // R4: start under a non-frequency mode is ignored
    write_cfg(1, 0);
    do_start(t0);
    repeat (4) @(negedge clk);
    check(done_o === 1'b1 && busy_o === 1'b0 && result_o == 20'(held), "R4 start ignored", result_o, held);
    write_cfg(3, 2);
    do_start(t0);
    pulse(1'b0, c);
    check(done_o === 1'b1 && result_o == 20'(held), "R4 start ignored mode 11", result_o, held);

    // R5: restart mid-window
    write_cfg(0, 2);
    do_start(t0);
    for (int i = 0; i < 5; i++) pulse(1'b0, c);
    do_start(t0);
    check(result_o == 20'd0 && busy_o === 1'b1, "R5 restart clears", result_o, 0);
    for (int i = 0; i < 7; i++) pulse(1'b0, c);
    wait_done(t0, 2);
    check(result_o == 20'd7, "R5 restart count", result_o, 7);

    // R8: config write during window affects only the next run
    write_cfg(0, 0);
    do_start(t0);
    write_cfg(0, 3);
    for (int i = 0; i < 2; i++) pulse(1'b0, c);
    wait_done(t0, 0);
    check(result_o == 20'd2, "R8 count", result_o, 2);
    run_meas(1'b0, 3, 3, 0);

    // R6: blocking during part of a window
    run_meas(1'b1, 0, 20, 50);

    // constrained random runs
    for (int r = 0; r < 10; r++) begin
      run_meas(1'b1, int'($urandom % 3), int'($urandom % 31), 25);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule